// File: doc/BRIEF.md
# Two-Stage Barrett CRC-32 Step Unit

This block advances a reflected CRC-32 register by 8, 16 or 32 bits in one operation, in the manner of a processor's CRC instructions. The caller has already merged the data into the low bits of the operand. The unit folds those bits through the chosen polynomial and returns the updated register value. Two polynomials are available: the Ethernet/zip CRC-32 and the Castagnoli CRC-32C.

The arithmetic uses Barrett reduction, not a bit-serial shift register and not a lookup table. In the first cycle, the operand, shifted so that its active bits sit at the top, is carry-less multiplied by the bit-reversed Barrett constant mu. The product is reversed and registered. In the second cycle, that value is carry-less multiplied by the polynomial in normal bit order. The product is reversed and XORed with the operand bits that were not consumed. The mu constants are derived at elaboration from the polynomials.

Operations enter on a valid/ready port and leave on a valid/ready port. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. A source may hold `in_valid` for as long as it likes. A sink may lower `out_ready` at any time. The two internal stages then fill and `in_ready` falls.

Top module: `crc_barrett_unit`

## Requirements
- R1: With `in_poly_sel` = 0 the result equals n steps of the reflected shift/XOR update with constant 0xEDB88320 applied to the operand (CRC-32).
- R2: With `in_poly_sel` = 1 the result equals the same n-step update with constant 0x82F63B78 (CRC-32C).
- R3: `in_size` code 2'b00 sets n = 8, 2'b01 sets n = 16 and 2'b10 sets n = 32. For n below 32, operand bits above bit n-1 reach the result shifted right by n.
- R4: `in_size` code 2'b11 behaves exactly like 2'b10 (n = 32).
- R5: When an operation is accepted in cycle c and `out_ready` stays high, `out_valid` is high in cycle c+2 and only in that cycle for that operation.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` does not change.
- R7: Results leave in acceptance order, each exactly once. `in_ready` is low only when both stages hold an operation and the output is stalled.
- R8: Operand and selects are captured at acceptance. Later changes on those inputs do not alter an accepted operation's result.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R10: Chaining byte operations over "123456789", starting from 0xFFFFFFFF and inverting the final value, gives 0xCBF43926 for CRC-32 and 0xE3069283 for CRC-32C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_operand | input | 32 | CRC register value with data already merged |
| in_poly_sel | input | 1 | 0 selects CRC-32, 1 selects CRC-32C |
| in_size | input | 2 | Bits folded: 00 = 8, 01 = 16, 10 or 11 = 32 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_result | output | 32 | Updated CRC register value |

## Verification
The checker places no limits on the inputs. A source may offer or withdraw an operation on any cycle, and a sink may stall for any length of time. The checker tracks how many operations are in flight. From that count it derives the stall, ordering and latency properties. It depends on both count and stages clearing together at reset. The stimulus applies no back-pressure in the latency and known-answer phases, so the two-cycle timing can be observed. A long random phase then toggles `out_ready` with random operands in all six modes. That phase fills both stages and holds results under stall.

// File: rtl/crc_bar_pkg.sv
package crc_bar_pkg;

  localparam int unsigned CRC_W = 32;

  typedef enum logic {
    POLY_CRC32  = 1'b0,
    POLY_CRC32C = 1'b1
  } poly_e;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'b00,
    SZ_HALF     = 2'b01,
    SZ_WORD     = 2'b10,
    SZ_WORD_ALT = 2'b11
  } size_e;

  // Reflected (LSB-first) polynomial constants.
  localparam logic [CRC_W-1:0] REFL_CRC32  = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] REFL_CRC32C = 32'h82F6_3B78;

  // Value handed from the first stage to the second.
  typedef struct packed {
    logic [CRC_W-1:0] partial;  // reversed first product
    logic [CRC_W-1:0] upper;    // operand bits not consumed, already shifted
    logic             sel;      // polynomial select
  } mid_t;

  function automatic logic [CRC_W-1:0] rev_bits(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  // floor(x^(2W) / G(x)), where G is the normal-order polynomial with its x^W term.
  function automatic logic [CRC_W:0] barrett_quot(input logic [CRC_W-1:0] pnorm);
    logic [2*CRC_W:0] rem;
    logic [2*CRC_W:0] g;
    logic [CRC_W:0]   q;
    rem = '0;
    rem[2*CRC_W] = 1'b1;
    g   = {{CRC_W{1'b0}}, 1'b1, pnorm};
    q   = '0;
    for (int i = 2*CRC_W; i >= CRC_W; i--) begin
      if (rem[i]) begin
        q[i-CRC_W] = 1'b1;
        rem = rem ^ (g << (i - CRC_W));
      end
    end
    return q;
  endfunction

  // Reverse the full (W+1)-bit quotient, then drop its top bit.
  function automatic logic [CRC_W-1:0] mu_reflected(input logic [CRC_W-1:0] pnorm);
    logic [CRC_W:0] q;
    logic [CRC_W:0] r;
    q = barrett_quot(pnorm);
    for (int i = 0; i <= CRC_W; i++) r[i] = q[CRC_W-i];
    return r[CRC_W-1:0];
  endfunction

endpackage

// File: rtl/crc_bar_clmul.sv
module crc_bar_clmul #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p_lo
);
  logic [W-1:0] pp [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = b[i] ? (a << i) : '0;
  end

  always_comb begin
    p_lo = '0;
    for (int i = 0; i < W; i++) p_lo = p_lo ^ pp[i];
  end
endmodule

// File: rtl/crc_bar_stage0.sv
module crc_bar_stage0
  import crc_bar_pkg::*;
#(
  parameter logic [CRC_W-1:0] REFL_A = REFL_CRC32,
  parameter logic [CRC_W-1:0] REFL_B = REFL_CRC32C
) (
  input  logic [CRC_W-1:0] operand,
  input  logic             sel,
  input  logic [1:0]       size,
  output mid_t             mid
);
  localparam logic [CRC_W-1:0] NORM_A = rev_bits(REFL_A);
  localparam logic [CRC_W-1:0] NORM_B = rev_bits(REFL_B);
  localparam logic [CRC_W-1:0] MU_A   = mu_reflected(NORM_A);
  localparam logic [CRC_W-1:0] MU_B   = mu_reflected(NORM_B);

  logic [CRC_W-1:0] top_aligned;
  logic [CRC_W-1:0] upper;
  logic [CRC_W-1:0] mu;
  logic [CRC_W-1:0] prod;

  always_comb begin
    unique case (size_e'(size))
      SZ_BYTE: begin
        top_aligned = operand << (CRC_W - 8);
        upper       = operand >> 8;
      end
      SZ_HALF: begin
        top_aligned = operand << (CRC_W - 16);
        upper       = operand >> 16;
      end
      default: begin
        top_aligned = operand;
        upper       = '0;
      end
    endcase
  end

  assign mu = sel ? MU_B : MU_A;

  crc_bar_clmul #(.W(CRC_W)) u_mul0 (
    .a    (top_aligned),
    .b    (mu),
    .p_lo (prod)
  );

  assign mid.partial = rev_bits(prod);
  assign mid.upper   = upper;
  assign mid.sel     = sel;
endmodule

// File: rtl/crc_bar_stage1.sv
module crc_bar_stage1
  import crc_bar_pkg::*;
#(
  parameter logic [CRC_W-1:0] REFL_A = REFL_CRC32,
  parameter logic [CRC_W-1:0] REFL_B = REFL_CRC32C
) (
  input  mid_t             mid,
  output logic [CRC_W-1:0] result
);
  localparam logic [CRC_W-1:0] NORM_A = rev_bits(REFL_A);
  localparam logic [CRC_W-1:0] NORM_B = rev_bits(REFL_B);

  logic [CRC_W-1:0] poly;
  logic [CRC_W-1:0] prod;

  assign poly = mid.sel ? NORM_B : NORM_A;

  crc_bar_clmul #(.W(CRC_W)) u_mul1 (
    .a    (mid.partial),
    .b    (poly),
    .p_lo (prod)
  );

  assign result = mid.upper ^ rev_bits(prod);
endmodule

// File: rtl/crc_barrett_unit.sv
module crc_barrett_unit
  import crc_bar_pkg::*;
#(
  parameter logic [31:0] REFL_A = REFL_CRC32,
  parameter logic [31:0] REFL_B = REFL_CRC32C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_operand,
  input  logic        in_poly_sel,
  input  logic [1:0]  in_size,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_result
);
  mid_t             mid_d, mid_q;
  logic             mid_v;
  logic [CRC_W-1:0] res_d, res_q;
  logic             res_v;
  logic             adv_out;

  crc_bar_stage0 #(.REFL_A(REFL_A), .REFL_B(REFL_B)) u_s0 (
    .operand (in_operand),
    .sel     (in_poly_sel),
    .size    (in_size),
    .mid     (mid_d)
  );

  crc_bar_stage1 #(.REFL_A(REFL_A), .REFL_B(REFL_B)) u_s1 (
    .mid    (mid_q),
    .result (res_d)
  );

  assign adv_out  = !res_v || out_ready;
  assign in_ready = !mid_v || adv_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_v <= 1'b0;
      res_v <= 1'b0;
    end else begin
      if (in_ready) mid_v <= in_valid;
      if (adv_out)  res_v <= mid_v;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) mid_q <= mid_d;
    if (adv_out && mid_v)     res_q <= res_d;
  end

  assign out_valid  = res_v;
  assign out_result = res_q;
endmodule

// File: rtl/crc_barrett_unit_chk.sv
module crc_barrett_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result
);
  logic       fire_in, fire_out;
  logic [1:0] inflight;

  assign fire_in  = in_valid && in_ready;
  assign fire_out = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= 2'd0;
    else        inflight <= inflight + {1'b0, fire_in} - {1'b0, fire_out};
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_in && inflight == 2'd0) |=> (!out_valid ##1 out_valid));

  assert_no_phantom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != 2'd0));

  assert_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight != 2'd3);

  assert_stall_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready && inflight == 2'd2));
endmodule

bind crc_barrett_unit crc_barrett_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/tb_crc_barrett_unit.sv
module tb_crc_barrett_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_poly_sel = 1'b0;
  logic [1:0]  in_size = 2'b00;
  logic [31:0] in_operand = '0;
  logic        out_ready;
  wire         in_ready, out_valid;
  wire  [31:0] out_result;

  int checks = 0, errors = 0, cyc = 0, n_done = 0;
  int ready_mode = 1;   // 0 low, 1 high, 2 random
  bit lat_mode = 1'b0;
  logic [31:0] last_res = '0;
  logic [31:0] exp_q[$];
  int          stamp_q[$];
  string       tag_q[$];

  crc_barrett_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_poly_sel(in_poly_sel), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial out_ready = 1'b1;
  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0:       out_ready = 1'b0;
      1:       out_ready = 1'b1;
      default: out_ready = ($urandom % 3) != 0;
    endcase
  end

  function automatic logic [31:0] ref_crc(logic [31:0] r, logic sel, logic [1:0] sz);
    int n;
    logic [31:0] p;
    n = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    p = sel ? 32'h82F63B78 : 32'hEDB88320;
    for (int i = 0; i < n; i++) r = r[0] ? ((r >> 1) ^ p) : (r >> 1);
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: offer one operation, push its expectation when it is accepted.
  task automatic send(logic [31:0] op, logic sel, logic [1:0] sz, string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; in_operand = op; in_poly_sel = sel; in_size = sz;
    do @(negedge clk); while (!in_ready);
    exp_q.push_back(ref_crc(op, sel, sz));
    stamp_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  // Drop valid and scramble the inputs (R8: must not disturb accepted work).
  task automatic go_idle();
    @(posedge clk); #1;
    in_valid = 1'b0; in_operand = $urandom; in_poly_sel = $urandom; in_size = $urandom;
  endtask

  task automatic drain();
    ready_mode = 1;
    for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
  endtask

  // Monitor / scoreboard, plus hold check under stall.
  logic        hold_seen = 1'b0;
  logic [31:0] hold_val = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_seen)
        check(out_valid && out_result == hold_val, "R6 hold under stall", out_result, hold_val);
      hold_seen = out_valid && !out_ready;
      hold_val  = out_result;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", out_result, 32'h0);
        end else begin
          logic [31:0] e;
          int st;
          string t;
          e = exp_q.pop_front(); st = stamp_q.pop_front(); t = tag_q.pop_front();
          check(out_result == e, t, out_result, e);
          if (lat_mode) check(cyc - st == 2, "R5 latency", cyc - st, 2);
        end
        last_res = out_result;
        n_done++;
      end
    end
  end

  task automatic chain(logic sel, logic [31:0] expect_crc, string tag);
    logic [31:0] r;
    string s;
    s = "123456789";
    r = 32'hFFFFFFFF;
    for (int i = 0; i < s.len(); i++) begin
      int target;
      target = n_done + 1;
      send(r ^ {24'h0, s[i]}, sel, 2'b00, tag);
      go_idle();
      while (n_done < target) @(negedge clk);
      r = last_res;
    end
    check((r ^ 32'hFFFFFFFF) == expect_crc, tag, r ^ 32'hFFFFFFFF, expect_crc);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);

    // Latency and each mode, isolated. R1 R2 R3 R4 R5 R8
    lat_mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        send($urandom, p[0], s[1:0], p ? "R2 crc32c mode" : "R1 crc32 mode");
        go_idle();
        repeat (4) @(negedge clk);
      end
    end
    send(32'hFFFFFFFF, 1'b0, 2'b00, "R3 byte all-ones");   go_idle(); repeat (4) @(negedge clk);
    send(32'h12345678, 1'b1, 2'b01, "R3 half pattern");    go_idle(); repeat (4) @(negedge clk);
    send(32'h00000000, 1'b0, 2'b10, "R3 word zero");       go_idle(); repeat (4) @(negedge clk);
    send(32'h80000001, 1'b1, 2'b11, "R4 alt word code");   go_idle(); repeat (4) @(negedge clk);
    send(32'hA5A5A5A5, 1'b0, 2'b11, "R8 inputs scrambled after accept"); go_idle();
    repeat (4) @(negedge clk);

    // Back-to-back with no stall.
    for (int i = 0; i < 20; i++) send($urandom, $urandom, $urandom, "R7 back-to-back");
    go_idle();
    drain();
    lat_mode = 1'b0;

    // Known answers via byte chaining. R10
    chain(1'b0, 32'hCBF43926, "R10 crc32 check value");
    chain(1'b1, 32'hE3069283, "R10 crc32c check value");

    // Full stall: fill both stages, confirm in_ready drops. R7
    ready_mode = 0;
    send(32'h0BADF00D, 1'b0, 2'b01, "R7 stall item 1");
    send(32'hDEADBEEF, 1'b1, 2'b00, "R7 stall item 2");
    @(posedge clk); #1 in_valid = 1'b1; in_operand = 32'h1; in_size = 2'b10; in_poly_sel = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b0, "R7 in_ready low when full", in_ready, 0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    drain();

    // Random stream with random back-pressure. R1 R2 R6 R7
    ready_mode = 2;
    for (int i = 0; i < 400; i++) begin
      send($urandom, $urandom, $urandom, "R7 random stream");
      if ($urandom % 4 == 0) go_idle();
    end
    go_idle();
    drain();
    check(exp_q.size() == 0, "R7 all results returned", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule